// File: doc/BRIEF.md
# Command-Sequence Chip Erase Sequencer

This block runs a whole-array electrical erase of a byte-wide non-volatile memory and then proves the result. In its default entry path it issues two unlock writes to a lower-level bus engine: a short strobe that carries pattern AA hex to location 5555 hex, then a long strobe that carries 10 hex to location 2AAA hex. The long strobe is the erase itself. An alternative entry path, chosen per run with a mode input, replaces both writes with one long strobe. During that strobe a dedicated output asks the bus engine to hold a select address line at erase voltage. Generating the high voltage is left to the bus engine. The sequencer only raises enables.

After each erase, the block walks the array from location 0 upward and issues one read per location. Every byte must come back as all ones. A bad byte in this first sweep costs one try. The erase is then repeated and the sweep resumes at the failing location. The 20th failing read ends the run as failed. When the first sweep reaches the last location, a second full sweep compares every byte again, and that sweep alone decides pass or fail. Strobe lengths come from a clock-frequency parameter and a scaling divisor. An unrelated bus write seen between the two unlock writes aborts the run.

Top module: `erase_seq`

## Requirements
- R1: In command mode, a start accepted while idle produces first a strobe of SHORT_CYC cycles (CLK_KHZ*50/(1000*TIME_DIV)) with bus_addr = 5555 hex and bus_data = AA hex, with hv_en high.
- R2: GAP_CYC cycles after the first strobe, a second strobe of LONG_CYC cycles (CLK_KHZ*100/TIME_DIV) follows, with bus_addr = 2AAA hex and bus_data = 10 hex. This strobe counts as one erase.
- R3: In alternative mode (alt_mode = 1 at start), each erase is a single strobe of LONG_CYC cycles with addr_hv high, bus_addr bit 10 = 1 and bits 8 and 11 = 0. addr_hv is never high outside such a strobe.
- R4: After an erase, rd_req reads locations in ascending order from 0. A read whose rd_data is all ones advances to the next location.
- R5: In the first sweep, a read that is not all ones repeats the erase (the full sequence of the latched mode), and the next read is the same location.
- R6: The MAX_TRIES-th (20th) failing read of the first sweep ends the run with fail. A run therefore applies at most 20 erases, and a location that first reads clean after the 20th erase still passes.
- R7: After the last location (MEM_BYTES-1) reads clean in the first sweep, all locations are read again from 0. Any bad byte in this sweep gives fail with no further erase, and a clean sweep gives pass.
- R8: ext_wr high while the sequencer waits between the two unlock strobes ends the run with abort, with no second strobe and hv_en low. ext_wr at any other time has no effect.
- R9: busy rises the cycle after an accepted start and falls when the result appears. start while busy is ignored.
- R10: pass, fail and abort are low after reset, at most one of them is high, and the result holds until the next accepted start.
- R11: lock is low after reset, rises at the end of the first erase strobe, and stays high until reset.
- R12: hv_en is high only during strobes and the gap between the unlock strobes. rd_req is never high together with hv_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only while idle) |
| alt_mode | input | 1 | Selects the single-pulse high-voltage entry path for this run |
| ext_wr | input | 1 | A foreign write seen on the shared bus |
| strobe | output | 1 | Write strobe to the bus engine |
| hv_en | output | 1 | High-voltage enable on the output-enable supply |
| addr_hv | output | 1 | Hold the erase-select address line at erase voltage |
| bus_addr | output | ADDR_W | Address carried with the strobe |
| bus_data | output | DATA_W | Data carried with the strobe |
| rd_req | output | 1 | One-cycle verify read request |
| rd_addr | output | ADDR_W | Location of the verify read |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | DATA_W | Read response data |
| busy | output | 1 | Run in progress |
| lock | output | 1 | Memory has been erased and stays in verify state |
| pass | output | 1 | Last run verified clean |
| fail | output | 1 | Last run failed verification |
| abort | output | 1 | Last run aborted by a foreign write |

## Verification
The hardest case to reach from the ports is the edge of the try limit. One location must stay bad for exactly 19 or exactly 20 erases while every other location is already clean, and the sweep must resume at that location after each re-erase. The bench gives each location a model with its own count of erases needed. The memory turns a byte clean only when the observed erase strobes reach that count, so both sides of the limit come from one setting. A second hard case is a byte that reads clean in the first sweep and bad in the second. The bench drives it with a per-location read counter. The abort case is reached by timing ext_wr to the gap that follows the first strobe.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNLOCK,
      ST_GAP,
      ST_ERASE,
      ST_HVERASE,
      ST_RD_REQ,
      ST_RD_WAIT
   } seq_state_t;

   typedef enum logic [1:0] {
      RES_NONE,
      RES_PASS,
      RES_FAIL,
      RES_ABORT
   } seq_result_t;

   // unlock write pair
   localparam logic [15:0] UNLOCK_ADDR = 16'h5555;
   localparam logic [7:0]  UNLOCK_DATA = 8'hAA;
   localparam logic [15:0] ERASE_ADDR  = 16'h2AAA;
   localparam logic [7:0]  ERASE_DATA  = 8'h10;

   // address pattern applied during the high-voltage entry pulse
   localparam logic [15:0] HV_ADDR     = 16'h0400;

endpackage

// File: rtl/erase_pulse_timer.sv
module erase_pulse_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/erase_addr_walker.sv
module erase_addr_walker #(
   parameter int AW   = 16,
   parameter int LAST = 65535
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          at_last
);

   localparam logic [AW-1:0] LAST_A = AW'(LAST);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (clr)    addr_q <= '0;
      else if (step)   addr_q <= addr_q + 1'b1;
   end

   assign addr    = addr_q;
   assign at_last = (addr_q == LAST_A);

endmodule

// File: rtl/erase_try_counter.sv
module erase_try_counter #(
   parameter int TW    = 5,
   parameter int LIMIT = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);

   localparam logic [TW-1:0] LAST_TRY = TW'(LIMIT - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (inc)   cnt_q <= cnt_q + 1'b1;
   end

   // the next failing read is the last one allowed
   assign at_limit = (cnt_q == LAST_TRY);

endmodule

// File: rtl/erase_seq.sv
module erase_seq
   import erase_seq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int MEM_BYTES = 65536,
   parameter int CLK_KHZ   = 125000,
   parameter int TIME_DIV  = 1,
   parameter int GAP_CYC   = 2,
   parameter int MAX_TRIES = 20,
   parameter bit ALT_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              alt_mode,
   input  logic              ext_wr,
   output logic              strobe,
   output logic              hv_en,
   output logic              addr_hv,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              lock,
   output logic              pass,
   output logic              fail,
   output logic              abort
);

   localparam int SHORT_CYC = (CLK_KHZ * 50) / (1000 * TIME_DIV);
   localparam int LONG_CYC  = (CLK_KHZ * 100) / TIME_DIV;
   localparam int CW        = $clog2(LONG_CYC + 1);
   localparam int TW        = $clog2(MAX_TRIES + 1);
   localparam int LAST_ADDR = MEM_BYTES - 1;
   localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

   // elaboration-time parameter checks
   if (SHORT_CYC < 1) begin : g_bad_short
      $error("erase_seq: SHORT_CYC below one cycle");
   end
   if (GAP_CYC < 1 || GAP_CYC > LONG_CYC) begin : g_bad_gap
      $error("erase_seq: GAP_CYC out of range");
   end
   if (ADDR_W < 15) begin : g_bad_aw
      $error("erase_seq: ADDR_W too narrow for the unlock addresses");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("erase_seq: DATA_W below 8");
   end
   if (MEM_BYTES < 2 || MEM_BYTES > (2 ** ADDR_W)) begin : g_bad_mem
      $error("erase_seq: MEM_BYTES does not fit ADDR_W");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("erase_seq: MAX_TRIES below one");
   end

   seq_state_t  state_q, state_d;
   seq_result_t res_q, res_d;
   logic        res_set;
   logic        mode_q, mode_d;
   logic        sweep2_q, sweep2_d;
   logic        lock_q, lock_set;
   logic        tmr_load, tmr_exp;
   logic [CW-1:0] tmr_val;
   logic        walk_clr, walk_step, at_last;
   logic        try_clr, try_inc, at_limit;
   logic        go_erase, go_alt;
   logic        alt_ok;
   logic        start_go;

   // alternative entry path is present only when enabled
   if (ALT_EN) begin : g_alt
      assign alt_ok = alt_mode;
   end else begin : g_no_alt
      assign alt_ok = 1'b0 & alt_mode;
   end

   erase_pulse_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   erase_addr_walker #(.AW(ADDR_W), .LAST(LAST_ADDR)) u_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (walk_clr),
      .step    (walk_step),
      .addr    (rd_addr),
      .at_last (at_last)
   );

   erase_try_counter #(.TW(TW), .LIMIT(MAX_TRIES)) u_tries (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (try_clr),
      .inc      (try_inc),
      .at_limit (at_limit)
   );

   assign start_go = (state_q == ST_IDLE) && start;

   always_comb begin
      state_d   = state_q;
      mode_d    = mode_q;
      sweep2_d  = sweep2_q;
      res_d     = RES_NONE;
      res_set   = 1'b0;
      lock_set  = 1'b0;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      walk_clr  = 1'b0;
      walk_step = 1'b0;
      try_clr   = 1'b0;
      try_inc   = 1'b0;
      go_erase  = 1'b0;
      go_alt    = mode_q;

      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               walk_clr = 1'b1;
               try_clr  = 1'b1;
               sweep2_d = 1'b0;
               mode_d   = alt_ok;
               go_alt   = alt_ok;
               go_erase = 1'b1;
            end
         end
         ST_UNLOCK: begin
            if (tmr_exp) begin
               state_d  = ST_GAP;
               tmr_load = 1'b1;
               tmr_val  = CW'(GAP_CYC - 1);
            end
         end
         ST_GAP: begin
            if (ext_wr) begin
               state_d = ST_IDLE;
               res_set = 1'b1;
               res_d   = RES_ABORT;
            end else if (tmr_exp) begin
               state_d  = ST_ERASE;
               tmr_load = 1'b1;
               tmr_val  = CW'(LONG_CYC - 1);
            end
         end
         ST_ERASE, ST_HVERASE: begin
            if (tmr_exp) begin
               state_d  = ST_RD_REQ;
               lock_set = 1'b1;
            end
         end
         ST_RD_REQ: begin
            state_d = ST_RD_WAIT;
         end
         ST_RD_WAIT: begin
            if (rd_valid) begin
               if (rd_data == ERASED) begin
                  if (!at_last) begin
                     walk_step = 1'b1;
                     state_d   = ST_RD_REQ;
                  end else if (sweep2_q) begin
                     state_d = ST_IDLE;
                     res_set = 1'b1;
                     res_d   = RES_PASS;
                  end else begin
                     sweep2_d = 1'b1;
                     walk_clr = 1'b1;
                     state_d  = ST_RD_REQ;
                  end
               end else if (sweep2_q || at_limit) begin
                  state_d = ST_IDLE;
                  res_set = 1'b1;
                  res_d   = RES_FAIL;
               end else begin
                  try_inc  = 1'b1;
                  go_erase = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase

      // common erase entry, shared by the first attempt and every retry
      if (go_erase) begin
         tmr_load = 1'b1;
         if (go_alt) begin
            state_d = ST_HVERASE;
            tmr_val = CW'(LONG_CYC - 1);
         end else begin
            state_d = ST_UNLOCK;
            tmr_val = CW'(SHORT_CYC - 1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mode_q   <= 1'b0;
         sweep2_q <= 1'b0;
         res_q    <= RES_NONE;
         lock_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         mode_q   <= mode_d;
         sweep2_q <= sweep2_d;
         if (start_go)     res_q <= RES_NONE;
         else if (res_set) res_q <= res_d;
         if (lock_set)     lock_q <= 1'b1;
      end
   end

   // outputs decoded from the state register
   always_comb begin
      bus_addr = '0;
      bus_data = '0;
      unique case (state_q)
         ST_UNLOCK: begin
            bus_addr = ADDR_W'(UNLOCK_ADDR);
            bus_data = DATA_W'(UNLOCK_DATA);
         end
         ST_GAP, ST_ERASE: begin
            bus_addr = ADDR_W'(ERASE_ADDR);
            bus_data = (state_q == ST_ERASE) ? DATA_W'(ERASE_DATA) : '0;
         end
         ST_HVERASE: bus_addr = ADDR_W'(HV_ADDR);
         default: ;
      endcase
   end

   assign strobe  = (state_q == ST_UNLOCK) || (state_q == ST_ERASE) ||
                    (state_q == ST_HVERASE);
   assign hv_en   = strobe || (state_q == ST_GAP);
   assign addr_hv = (state_q == ST_HVERASE);
   assign rd_req  = (state_q == ST_RD_REQ);
   assign busy    = (state_q != ST_IDLE);
   assign lock    = lock_q;
   assign pass    = (res_q == RES_PASS);
   assign fail    = (res_q == RES_FAIL);
   assign abort   = (res_q == RES_ABORT);

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
   parameter int ADDR_W    = 16,
   parameter int SHORT_CYC = 1,
   parameter int LONG_CYC  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strobe,
   input logic              hv_en,
   input logic              addr_hv,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rd_req,
   input logic              busy,
   input logic              lock,
   input logic              pass,
   input logic              fail,
   input logic              abort
);

   int run_q;

   // length of the strobe run that just ended
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= 0;
      else if (strobe) run_q <= run_q + 1;
      else             run_q <= 0;
   end

   a_r1_strobe_has_hv: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> hv_en);

   a_r2_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && run_q != 0) |-> (run_q == SHORT_CYC || run_q == LONG_CYC));

   a_r3_hv_line_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hv |-> (strobe && bus_addr[10] && !bus_addr[8] && !bus_addr[11]));

   a_r12_no_read_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !hv_en);

   a_r12_hv_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      hv_en |-> busy);

   a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pass, fail, abort}));

   a_r9_no_result_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(pass || fail || abort));

   a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   a_r8_abort_drops_hv: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort) |-> !hv_en);

endmodule

bind erase_seq erase_seq_chk #(
   .ADDR_W    (ADDR_W),
   .SHORT_CYC (SHORT_CYC),
   .LONG_CYC  (LONG_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strobe   (strobe),
   .hv_en    (hv_en),
   .addr_hv  (addr_hv),
   .bus_addr (bus_addr),
   .rd_req   (rd_req),
   .busy     (busy),
   .lock     (lock),
   .pass     (pass),
   .fail     (fail),
   .abort    (abort)
);

// File: tb/erase_seq_test.sv
module erase_seq_test;

   localparam int AW    = 16;
   localparam int NB    = 16;
   localparam int SHORT = 1;     // 80000*50/(1000*4000)
   localparam int LONG  = 2000;  // 80000*100/4000

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0, alt_mode = 1'b0, ext_wr = 1'b0;
   logic          strobe, hv_en, addr_hv, rd_req, busy, lock, pass, fail, abort;
   logic [AW-1:0] bus_addr, rd_addr;
   logic [7:0]    bus_data;
   logic          rd_valid = 1'b0;
   logic [7:0]    rd_data = 8'h00;

   erase_seq #(
      .ADDR_W(AW), .DATA_W(8), .MEM_BYTES(NB), .CLK_KHZ(80000),
      .TIME_DIV(4000), .GAP_CYC(2), .MAX_TRIES(20), .ALT_EN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .alt_mode(alt_mode),
      .ext_wr(ext_wr), .strobe(strobe), .hv_en(hv_en), .addr_hv(addr_hv),
      .bus_addr(bus_addr), .bus_data(bus_data), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .busy(busy), .lock(lock), .pass(pass), .fail(fail), .abort(abort)
   );

   int n_chk = 0, n_bad = 0;
   bit done_flag = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // memory model
   int need [NB];
   int seen [NB];
   int flaky_addr = -1;
   int erase_cnt = 0, read_cnt = 0, nxt_addr = 0;
   bit armed = 0, resp_pend = 0;
   logic [7:0] resp_data;

   always @(negedge clk) begin
      if (resp_pend) begin
         rd_valid  = 1'b1;
         rd_data   = resp_data;
         resp_pend = 0;
      end else begin
         rd_valid = 1'b0;
      end
      if (rd_req) begin
         int a;
         bit good;
         a = int'(rd_addr);
         check(a == nxt_addr, "R4 read order", a, nxt_addr);
         read_cnt++;
         if (a < NB) begin
            seen[a]++;
            good = (erase_cnt >= need[a]) && !(a == flaky_addr && seen[a] == 2);
         end else begin
            good = 0;
         end
         resp_data = good ? 8'hFF : 8'h7E;
         resp_pend = 1;
         nxt_addr  = good ? ((a == NB - 1) ? 0 : a + 1) : a;
      end
   end

   // strobe monitor
   int run = 0;
   logic [AW-1:0] p_addr;
   logic [7:0]    p_data;
   bit            p_hv;

   always @(negedge clk) begin
      if (strobe) begin
         run++;
         p_addr = bus_addr;
         p_data = bus_data;
         p_hv   = addr_hv;
      end else if (run > 0) begin
         if (p_hv) begin
            check(run == LONG, "R3 pulse width", run, LONG);
            check(p_addr[10] && !p_addr[8] && !p_addr[11], "R3 address pattern", p_addr, 16'h0400);
            erase_cnt++;
         end else if (p_data == 8'hAA) begin
            check(run == SHORT, "R1 unlock width", run, SHORT);
            check(p_addr == 16'h5555, "R1 unlock address", p_addr, 16'h5555);
            armed = 1;
         end else begin
            check(run == LONG, "R2 erase width", run, LONG);
            check(p_addr == 16'h2AAA && p_data == 8'h10 && armed, "R2 erase write",
                  {p_addr, p_data}, {16'h2AAA, 8'h10});
            erase_cnt++;
            armed = 0;
         end
         run = 0;
      end
   end

   // scoreboard
   typedef struct {
      int res;
      int erases;
      int reads;
      string req;
   } exp_t;
   exp_t sb_q[$];
   bit busy_prev = 0;

   always @(negedge clk) begin
      if (busy_prev && !busy) begin
         int got;
         got = pass ? 1 : fail ? 2 : abort ? 3 : 0;
         if (sb_q.size() == 0) begin
            check(0, "R9 unexpected completion", got, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(got == e.res, {e.req, " result"}, got, e.res);
            check(erase_cnt == e.erases, {e.req, " erase count"}, erase_cnt, e.erases);
            check(read_cnt == e.reads, {e.req, " read count"}, read_cnt, e.reads);
         end
      end
      busy_prev = busy;
   end

   task automatic prep();
      for (int i = 0; i < NB; i++) need[i] = 1;
      flaky_addr = -1;
   endtask

   task automatic run_case(input bit alt, input int res, input int er, input int rd, input string req);
      exp_t e;
      erase_cnt = 0;
      read_cnt  = 0;
      nxt_addr  = 0;
      armed     = 0;
      for (int i = 0; i < NB; i++) seen[i] = 0;
      e.res = res; e.erases = er; e.reads = rd; e.req = req;
      sb_q.push_back(e);
      @(negedge clk);
      start    = 1'b1;
      alt_mode = alt;
      @(negedge clk);
      start    = 1'b0;
      alt_mode = 1'b0;
      check(busy == 1'b1, "R9 busy after start", busy, 1);
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_strobe(input logic [7:0] d);
      do @(negedge clk); while (!(strobe && bus_data == d));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !strobe && !hv_en && !rd_req, "R10 reset idle", {busy, strobe, hv_en, rd_req}, 0);
      check(!pass && !fail && !abort, "R10 reset results", {pass, fail, abort}, 0);
      check(!lock, "R11 reset lock", lock, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8: foreign write in the gap aborts
      prep();
      fork
         run_case(0, 3, 0, 0, "R8 abort");
         begin
            wait_strobe(8'hAA);
            while (strobe) @(negedge clk);
            ext_wr = 1'b1;
            @(negedge clk);
            ext_wr = 1'b0;
         end
      join
      check(!hv_en && !strobe, "R8 hv off after abort", hv_en, 0);
      check(!lock, "R11 no lock without erase", lock, 0);
      repeat (5) @(negedge clk);
      check(abort && !pass && !fail, "R10 result held", {pass, fail, abort}, 1);

      // R4: plain pass
      prep();
      run_case(0, 1, 1, 32, "R4 clean pass");
      check(lock, "R11 lock after erase", lock, 1);

      // R5: one byte needs three erases
      prep();
      need[5] = 3;
      run_case(0, 1, 3, 34, "R5 retry resume");

      // R8: ext_wr during pulses is ignored
      prep();
      fork
         run_case(0, 1, 1, 32, "R8 ext_wr outside gap");
         begin
            wait_strobe(8'hAA);
            ext_wr = 1'b1;
            @(negedge clk);
            ext_wr = 1'b0;
            wait_strobe(8'h10);
            ext_wr = 1'b1;
            repeat (3) @(negedge clk);
            ext_wr = 1'b0;
         end
      join

      // R9: start during the run is ignored
      prep();
      fork
         run_case(0, 1, 1, 32, "R9 start ignored");
         begin
            do @(negedge clk); while (!rd_req);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      join

      // R7: byte bad only in the second sweep
      prep();
      flaky_addr = 7;
      run_case(0, 2, 1, 24, "R7 second sweep fail");

      // R3: high-voltage entry path
      prep();
      run_case(1, 1, 1, 32, "R3 alt mode pass");

      // R6: clean after the 20th erase passes
      prep();
      need[2] = 20;
      run_case(0, 1, 20, 51, "R6 limit pass");

      // R6: still bad after 20 erases fails
      prep();
      need[2] = 25;
      run_case(0, 2, 20, 22, "R6 limit fail");
      check(lock, "R11 lock held", lock, 1);

      rst_n = 1'b0;
      @(negedge clk);
      check(!lock && !pass && !fail && !abort, "R11 reset clears lock", {lock, pass, fail, abort}, 0);

      if (!done_flag) begin
         done_flag = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule